// File: doc/BRIEF.md
# Tearing-Effect Start Gate

This block decides when a panel data transfer may begin. A transmit sequencer raises a one-cycle request together with the sync mode taken from the current transfer descriptor. In the no-sync modes the gate answers with a one-cycle grant at once. In the two sync modes the gate waits for the chosen edge on the panel's tearing-effect line. It then counts out a delay and grants the transfer when the delay ends.

The delay is measured by two prescaler stages in series. The first stage divides the module clock by a power of two. The second divides the first stage's ticks by another power of two. The delay counter counts ticks of the second stage. The tearing-effect line is asynchronous to the module clock, so it passes through a two-flop synchroniser before the edge detector. Usually only the first descriptor of a frame asks for sync. Later descriptors in the same frame use mode 0 and start at once.

Top module: `te_start_gate`

## Requirements
- R1: While reset is active, and after reset until a request is served, `grant` stays low.
- R2: A request accepted while idle with `syncSel` = 0 raises `grant` for one cycle, on the clock edge after the request is sampled.
- R3: Value 3 of `syncSel` is reserved and behaves exactly like value 0.
- R4: With `syncSel` = 1 and a zero delay, the gate waits for a low-to-high change of `tePin`. Two synchroniser flops and an edge register lie in the path, so `grant` rises on the third rising clock edge after the pin changes.
- R5: With `syncSel` = 2 the gate waits for a high-to-low change of `tePin`. A low-to-high change while waiting is ignored.
- R6: After the selected edge, the grant comes `delayUnits` × 2^`ratioFast` × 2^`ratioSlow` clock cycles later than it would with a zero delay.
- R7: The mode, both ratio fields and the delay count are sampled when a request is accepted. Later changes on those inputs do not affect the transfer in progress.
- R8: An edge counts only if the edge detector reports it in a cycle after the request was accepted. An edge reported in the same cycle as the request, or earlier, is missed, and the gate waits for the next matching edge.
- R9: A request that arrives while the gate is waiting for an edge or counting the delay is ignored. It produces no grant and does not restart the wait.
- R10: Each accepted request produces exactly one single-cycle grant. Requests on consecutive cycles in mode 0 produce grants on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tePin | input | 1 | Raw tearing-effect line from the panel (asynchronous) |
| startReq | input | 1 | One-cycle request to start a transfer |
| syncSel | input | 2 | 0 none, 1 rising edge, 2 falling edge, 3 reserved (none) |
| ratioFast | input | RATIO_W | First prescaler stage divides the clock by 2^ratioFast |
| ratioSlow | input | RATIO_W | Second stage divides first-stage ticks by 2^ratioSlow |
| delayUnits | input | DELAY_W | Delay after the edge, counted in second-stage periods |
| grant | output | 1 | One-cycle pulse that releases the transfer |

## Verification
Two events can fall in the same cycle: a new request being accepted, and the synchronised edge detector reporting an edge. The bench drives the pin change, then places the request so that it is sampled on the edge at which the detector fires. It expects the edge to be missed, with no grant until the next matching edge. The bench also moves the request one cycle earlier and expects the grant on the third clock edge after the pin change. A second coincidence is a late request that arrives during the delay count, in the cycles before the grant. The scoreboard requires that this request adds no grant and does not move the grant's cycle.

// File: rtl/te_gate_pkg.sv
package te_gate_pkg;

  // Sync mode encodings carried in from the descriptor
  typedef enum logic [1:0] {
    SYNC_NONE = 2'd0,
    SYNC_RISE = 2'd1,
    SYNC_FALL = 2'd2,
    SYNC_RSVD = 2'd3
  } syncMode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DELAY = 2'd2
  } gateState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;   // capture mode, ratios and delay count
    logic armDelay;  // clear prescalers, load delay counter
    logic runDelay;  // prescalers and delay counter advance
  } gateStrobe_t;

endpackage

// File: rtl/te_gate_prescale.sv
module te_gate_prescale #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clr,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio,
  output logic               atLimit
);
  localparam int CNT_W = (1 << RATIO_W);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] span;

  // terminal count is 2^ratio - 1
  assign span    = (ONE << ratio) - ONE;
  assign atLimit = (cnt == span);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= atLimit ? '0 : cnt + ONE;
    end
  end
endmodule

// File: rtl/te_gate_dp.sv
module te_gate_dp
  import te_gate_pkg::*;
#(
  parameter int DELAY_W = 8,
  parameter int RATIO_W = 3,
  parameter int STAGES  = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            tePin,
  input  logic [1:0]                      syncSel,
  input  logic [STAGES-1:0][RATIO_W-1:0]  ratioIn,
  input  logic [DELAY_W-1:0]              delayUnits,
  input  gateStrobe_t                     strobe,
  output logic                            edgeHit,
  output logic                            delayIsZero,
  output logic                            delayDone,
  output logic [1:0]                      modeQ,
  output logic [DELAY_W-1:0]              delayQ
);
  localparam logic [DELAY_W-1:0] DLY_ONE = {{(DELAY_W-1){1'b0}}, 1'b1};

  logic teMeta, teSync, tePrev;
  logic riseSeen, fallSeen;
  logic [STAGES-1:0][RATIO_W-1:0] ratioQ;
  logic [STAGES-1:0] stageEn;
  logic [STAGES-1:0] atLimit;
  logic lastTick;
  logic [DELAY_W-1:0] remaining;

  // two-flop synchroniser plus one register for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      teMeta <= 1'b0;
      teSync <= 1'b0;
      tePrev <= 1'b0;
    end else begin
      teMeta <= tePin;
      teSync <= teMeta;
      tePrev <= teSync;
    end
  end

  assign riseSeen = teSync & ~tePrev;
  assign fallSeen = ~teSync & tePrev;
  assign edgeHit  = ((modeQ == SYNC_RISE) & riseSeen) |
                    ((modeQ == SYNC_FALL) & fallSeen);

  // per-transfer configuration capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= SYNC_NONE;
      ratioQ <= '0;
      delayQ <= '0;
    end else if (strobe.loadCfg) begin
      modeQ  <= syncSel;
      ratioQ <= ratioIn;
      delayQ <= delayUnits;
    end
  end

  assign delayIsZero = (delayQ == '0);

  // cascaded power-of-two prescaler
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stageEn[g] = strobe.runDelay;
    end else begin : g_next
      assign stageEn[g] = strobe.runDelay & (&atLimit[g-1:0]);
    end
    te_gate_prescale #(.RATIO_W(RATIO_W)) u_stage (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (strobe.armDelay),
      .en     (stageEn[g]),
      .ratio  (ratioQ[g]),
      .atLimit(atLimit[g])
    );
  end

  assign lastTick  = strobe.runDelay & (&atLimit);
  assign delayDone = lastTick & (remaining == DLY_ONE);

  // delay counter in last-stage periods
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
    end else if (strobe.armDelay) begin
      remaining <= delayQ;
    end else if (lastTick) begin
      remaining <= remaining - DLY_ONE;
    end
  end
endmodule

// File: rtl/te_gate_ctrl.sv
module te_gate_ctrl
  import te_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [1:0]  syncSel,
  input  logic        edgeHit,
  input  logic        delayIsZero,
  input  logic        delayDone,
  output gateStrobe_t strobe,
  output logic        grant,
  output logic        idleS,
  output logic        waitS
);
  gateState_e state, nextState;
  logic grantNext;

  always_comb begin
    strobe    = '0;
    nextState = state;
    grantNext = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.loadCfg = 1'b1;
          if (syncSel == SYNC_RISE || syncSel == SYNC_FALL) begin
            nextState = ST_WAIT;
          end else begin
            grantNext = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (edgeHit) begin
          if (delayIsZero) begin
            grantNext = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strobe.armDelay = 1'b1;
            nextState       = ST_DELAY;
          end
        end
      end
      ST_DELAY: begin
        strobe.runDelay = 1'b1;
        if (delayDone) begin
          grantNext = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      grant <= 1'b0;
    end else begin
      state <= nextState;
      grant <= grantNext;
    end
  end

  assign idleS = (state == ST_IDLE);
  assign waitS = (state == ST_WAIT);
endmodule

// File: rtl/te_start_gate.sv
module te_start_gate
  import te_gate_pkg::*;
#(
  parameter int DELAY_W = 8,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tePin,
  input  logic               startReq,
  input  logic [1:0]         syncSel,
  input  logic [RATIO_W-1:0] ratioFast,
  input  logic [RATIO_W-1:0] ratioSlow,
  input  logic [DELAY_W-1:0] delayUnits,
  output logic               grant
);
  localparam int STAGES = 2;

  gateStrobe_t strobe;
  logic edgeHit, delayIsZero, delayDone;
  logic idleS, waitS;
  logic [1:0] modeQ;
  logic [DELAY_W-1:0] delayQ;
  logic [STAGES-1:0][RATIO_W-1:0] ratioIn;

  assign ratioIn = {ratioSlow, ratioFast};

  te_gate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .syncSel    (syncSel),
    .edgeHit    (edgeHit),
    .delayIsZero(delayIsZero),
    .delayDone  (delayDone),
    .strobe     (strobe),
    .grant      (grant),
    .idleS      (idleS),
    .waitS      (waitS)
  );

  te_gate_dp #(
    .DELAY_W(DELAY_W),
    .RATIO_W(RATIO_W),
    .STAGES (STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tePin      (tePin),
    .syncSel    (syncSel),
    .ratioIn    (ratioIn),
    .delayUnits (delayUnits),
    .strobe     (strobe),
    .edgeHit    (edgeHit),
    .delayIsZero(delayIsZero),
    .delayDone  (delayDone),
    .modeQ      (modeQ),
    .delayQ     (delayQ)
  );
endmodule

// File: rtl/te_start_gate_chk.sv
module te_start_gate_chk #(
  parameter int DELAY_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               startReq,
  input logic [1:0]         syncSel,
  input logic               grant,
  input logic               idleS,
  input logic               waitS,
  input logic               edgeHit,
  input logic               delayIsZero,
  input logic [1:0]         modeQ,
  input logic [DELAY_W-1:0] delayQ
);
  // R2 and R3: no-sync request grants on the next edge
  p_nosync_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && idleS && (syncSel == 2'd0 || syncSel == 2'd3)) |=> grant);

  // R4 and R5: no grant while waiting without a matching edge
  p_wait_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (waitS && !edgeHit) |=> !grant);

  // R4: zero delay grants on the edge after detection
  p_zero_delay_r4: assert property (@(posedge clk) disable iff (!rstN)
    (waitS && edgeHit && delayIsZero) |=> grant);

  // R7: captured configuration holds while waiting
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    waitS |=> ($stable(modeQ) && $stable(delayQ)));

  // R9: request during wait does not restart or leave the wait
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (waitS && startReq && !edgeHit) |=> waitS);

  // R10: grant is a single pulse unless a fresh request arrives
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    (grant && !startReq) |=> !grant);
endmodule

bind te_start_gate te_start_gate_chk #(.DELAY_W(DELAY_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .syncSel    (syncSel),
  .grant      (grant),
  .idleS      (idleS),
  .waitS      (waitS),
  .edgeHit    (edgeHit),
  .delayIsZero(delayIsZero),
  .modeQ      (modeQ),
  .delayQ     (delayQ)
);

// File: tb/tb_te_start_gate.sv
module tb_te_start_gate;
  localparam int DW = 8;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tePin = 1'b0;
  logic startReq = 1'b0;
  logic [1:0] syncSel = 2'd0;
  logic [RW-1:0] ratioFast = '0;
  logic [RW-1:0] ratioSlow = '0;
  logic [DW-1:0] delayUnits = '0;
  logic grant;

  typedef struct {
    int    cyc;
    string tag;
  } expItem_t;

  expItem_t sbq[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;

  te_start_gate #(.DELAY_W(DW), .RATIO_W(RW)) dut (
    .clk       (clk),
    .rstN      (rstN),
    .tePin     (tePin),
    .startReq  (startReq),
    .syncSel   (syncSel),
    .ratioFast (ratioFast),
    .ratioSlow (ratioSlow),
    .delayUnits(delayUnits),
    .grant     (grant)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops the scoreboard whenever a grant appears
  always @(negedge clk) begin
    expItem_t it;
    if (rstN && grant) begin
      checks++;
      if (sbq.size() == 0) begin
        failures++;
        $display("FAIL R9/R10 unexpected grant: actual cycle %0d, expected none", cyc);
      end else begin
        it = sbq.pop_front();
        if (it.cyc != cyc) begin
          failures++;
          $display("FAIL %s grant cycle: actual %0d, expected %0d", it.tag, cyc, it.cyc);
        end
      end
    end
  end

  task automatic expectAt(input int c, input string tag);
    expItem_t it;
    it.cyc = c;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic issue(input logic [1:0] m, input int rf, input int rs, input int d);
    syncSel    = m;
    ratioFast  = RW'(rf);
    ratioSlow  = RW'(rs);
    delayUnits = DW'(d);
    startReq   = 1'b1;
    @(negedge clk);
    startReq   = 1'b0;
  endtask

  task automatic quietFor(input int n, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (grant) seen = 1'b1;
    end
    checks++;
    if (seen) begin
      failures++;
      $display("FAIL %s grant while quiet: actual 1, expected 0", tag);
    end
  endtask

  task automatic drain();
    int n = 0;
    expItem_t it;
    while (sbq.size() > 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      checks++;
      failures++;
      $display("FAIL %s missing grant: actual none, expected cycle %0d", it.tag, it.cyc);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(10 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c0;
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (grant !== 1'b0) begin
      failures++;
      $display("FAIL R1 grant in reset: actual %b, expected 0", grant);
    end
    rstN = 1'b1;
    quietFor(4, "R1");

    // R2: mode 0
    expectAt(cyc + 1, "R2");
    issue(2'd0, 0, 0, 0);
    drain();

    // R3: reserved mode acts as none
    expectAt(cyc + 1, "R3");
    issue(2'd3, 2, 2, 5);
    drain();

    // R4: rising edge, zero delay
    issue(2'd1, 0, 0, 0);
    quietFor(5, "R4");
    tePin = 1'b1;
    expectAt(cyc + 3, "R4");
    drain();

    // R5: falling mode ignores a rising edge
    tePin = 1'b0;
    quietFor(5, "R5");
    issue(2'd2, 0, 0, 0);
    quietFor(3, "R5");
    tePin = 1'b1;
    quietFor(8, "R5");
    tePin = 1'b0;
    expectAt(cyc + 3, "R5");
    drain();

    // R6: delay = 3 * 2^1 * 2^2
    issue(2'd1, 1, 2, 3);
    quietFor(4, "R6");
    tePin = 1'b1;
    expectAt(cyc + 3 + 24, "R6");
    drain();
    // R6: largest ratios, delay = 1 * 2^3 * 2^3
    tePin = 1'b0;
    quietFor(5, "R6");
    issue(2'd1, 3, 3, 1);
    tePin = 1'b1;
    expectAt(cyc + 3 + 64, "R6");
    drain();

    // R7: inputs changed after acceptance have no effect
    tePin = 1'b0;
    quietFor(5, "R7");
    issue(2'd1, 2, 0, 2);
    delayUnits = DW'(9);
    ratioFast  = '0;
    syncSel    = 2'd2;
    quietFor(3, "R7");
    tePin = 1'b1;
    expectAt(cyc + 3 + 8, "R7");
    drain();

    // R8: edge detected in the acceptance cycle is missed
    tePin = 1'b0;
    quietFor(5, "R8");
    c0 = cyc;
    tePin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (cyc != c0 + 2) $display("note: cycle skew %0d", cyc - c0);
    issue(2'd1, 0, 0, 0);
    quietFor(8, "R8");
    tePin = 1'b0;
    quietFor(5, "R8");
    tePin = 1'b1;
    expectAt(cyc + 3, "R8");
    drain();
    // R8: one cycle earlier the edge is caught
    tePin = 1'b0;
    quietFor(5, "R8");
    c0 = cyc;
    tePin = 1'b1;
    @(negedge clk);
    expectAt(c0 + 3, "R8");
    issue(2'd1, 0, 0, 0);
    drain();

    // R9: requests while waiting and while delaying are ignored
    tePin = 1'b0;
    quietFor(5, "R9");
    issue(2'd1, 0, 0, 4);
    quietFor(2, "R9");
    issue(2'd0, 0, 0, 0);
    quietFor(3, "R9");
    c0 = cyc;
    tePin = 1'b1;
    expectAt(c0 + 3 + 4, "R9");
    repeat (3) @(negedge clk);
    issue(2'd0, 0, 0, 0);
    drain();

    // R10: back-to-back requests give back-to-back single grants
    expectAt(cyc + 1, "R10");
    expectAt(cyc + 2, "R10");
    syncSel  = 2'd0;
    startReq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    startReq = 1'b0;
    drain();
    quietFor(6, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule